// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block sits between two independent access ports, left and right, and the shared storage array they both reach. Each port presents an enable, a write strobe and an address every clock cycle. When both ports are enabled on the same address, the block picks one owner for that location. It raises a registered busy flag toward the other port and holds back that port's write strobe, so it never reaches the array.

A port that was already sitting on the location keeps it. If both arrive in the same cycle, the left port wins. The flag can rise in two ways: an enable turns on while the addresses already agree, or the addresses come to agree while both enables are on. The `is_master` input picks where the flags come from. In master mode they come from the local arbitration. In slave mode they are copied from busy inputs driven by another device's flags, so several devices can be cascaded to form a wider word and all of them block the same writes.

Top module: `dp_contention_arb`

## Requirements
- R1: A port's busy flag is never raised unless both enables were high and the two addresses were equal in the previous cycle; differing addresses or a single enabled port give busy low on both sides.
- R2: In master mode the two busy flags are never high in the same cycle.
- R3: When one port was enabled on an address in the previous cycle and the other port newly arrives on it, the port already present owns the location and the newcomer gets busy.
- R4: When both ports arrive on a matching address in the same cycle, neither having held it the cycle before, the left port owns it and the right port gets busy.
- R5: Busy is raised whether the match forms because an enable turns on over equal addresses or because an address changes to equal the other port's.
- R6: Busy is registered. It is high in the cycle after a contention cycle and low in the cycle after the first cycle with no contention.
- R7: The memory write strobe of a port is high one cycle after that port had enable and write both high, except when that port's busy flag is high in the same cycle; a busy port's strobe is always low.
- R8: In master mode (`is_master` = 1) the busy inputs have no effect on the outputs.
- R9: In slave mode (`is_master` = 0) each busy output equals its busy input one cycle earlier and local arbitration has no effect; writes are blocked by that input value.
- R10: `rst` is synchronous and active high. While it is high, every output is low at the next edge and ownership history is cleared, so after release the next match is treated as a same-cycle arrival.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| is_master | input | 1 | 1 = arbitrate locally, 0 = follow busy inputs |
| left_en | input | 1 | Left port enable |
| left_wr | input | 1 | Left port write strobe |
| left_addr | input | AW | Left port address |
| right_en | input | 1 | Right port enable |
| right_wr | input | 1 | Right port write strobe |
| right_addr | input | AW | Right port address |
| left_busy_in | input | 1 | Left busy from a master device (slave mode) |
| right_busy_in | input | 1 | Right busy from a master device (slave mode) |
| left_busy | output | 1 | Busy flag to the left port |
| right_busy | output | 1 | Busy flag to the right port |
| left_mem_wr | output | 1 | Gated write strobe to the array, left side |
| right_mem_wr | output | 1 | Gated write strobe to the array, right side |

## Verification
Every result of this block passes through exactly one register. The busy flags and the gated write strobes therefore reflect the port inputs of the cycle before, and in slave mode the busy inputs of the cycle before. The bench drives each stimulus on the falling edge and reads the outputs at the next falling edge, one rising edge later, so each check lands on the cycle its result is due. Ownership depends on what each port held in the prior cycle, so the table vectors run in a fixed order, and each expected value takes that history into account.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } dpa_owner_e;

  localparam int unsigned NPORT = 2;
  localparam int unsigned PL = 0;
  localparam int unsigned PR = 1;
endpackage

// File: rtl/dpa_hold.sv
module dpa_hold #(
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [AW-1:0] addr,
  output logic          held
);
  logic          en_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      en_q   <= en;
      addr_q <= addr;
    end
  end

  // port was already on this same address last cycle
  assign held = en & en_q & (addr == addr_q);
endmodule

// File: rtl/dpa_owner.sv
module dpa_owner
  import dpa_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       hit,
  input  logic       held_l,
  input  logic       held_r,
  output dpa_owner_e owner_nxt
);
  dpa_owner_e owner_q;

  always_comb begin
    if (!hit)
      owner_nxt = OWN_NONE;
    else if (owner_q == OWN_LEFT && held_l)
      owner_nxt = OWN_LEFT;
    else if (owner_q == OWN_RIGHT && held_r)
      owner_nxt = OWN_RIGHT;
    else if (held_r && !held_l)
      owner_nxt = OWN_RIGHT;
    else
      owner_nxt = OWN_LEFT;
  end

  always_ff @(posedge clk) begin
    if (rst) owner_q <= OWN_NONE;
    else     owner_q <= owner_nxt;
  end
endmodule

// File: rtl/dpa_side.sv
module dpa_side (
  input  logic clk,
  input  logic rst,
  input  logic is_master,
  input  logic en,
  input  logic wr,
  input  logic lose,
  input  logic busy_in,
  output logic busy,
  output logic mem_wr
);
  logic busy_nxt;

  assign busy_nxt = is_master ? lose : busy_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      mem_wr <= 1'b0;
    end else begin
      busy   <= busy_nxt;
      mem_wr <= en & wr & ~busy_nxt;
    end
  end
endmodule

// File: rtl/dp_contention_arb.sv
module dp_contention_arb
  import dpa_pkg::*;
#(
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          is_master,
  input  logic          left_en,
  input  logic          left_wr,
  input  logic [AW-1:0] left_addr,
  input  logic          right_en,
  input  logic          right_wr,
  input  logic [AW-1:0] right_addr,
  input  logic          left_busy_in,
  input  logic          right_busy_in,
  output logic          left_busy,
  output logic          right_busy,
  output logic          left_mem_wr,
  output logic          right_mem_wr
);
  logic [NPORT-1:0]   en_v, wr_v, held_v, lose_v, bin_v, busy_v, mwr_v;
  logic [AW-1:0]      addr_v [NPORT];
  logic               hit;
  dpa_owner_e         owner_nxt;

  assign en_v   = {right_en, left_en};
  assign wr_v   = {right_wr, left_wr};
  assign bin_v  = {right_busy_in, left_busy_in};
  assign addr_v[PL] = left_addr;
  assign addr_v[PR] = right_addr;

  assign hit = left_en & right_en & (left_addr == right_addr);

  assign lose_v[PL] = (owner_nxt == OWN_RIGHT);
  assign lose_v[PR] = (owner_nxt == OWN_LEFT);

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpa_hold #(.AW(AW)) u_hold (
      .clk  (clk),
      .rst  (rst),
      .en   (en_v[p]),
      .addr (addr_v[p]),
      .held (held_v[p])
    );

    dpa_side u_side (
      .clk       (clk),
      .rst       (rst),
      .is_master (is_master),
      .en        (en_v[p]),
      .wr        (wr_v[p]),
      .lose      (lose_v[p]),
      .busy_in   (bin_v[p]),
      .busy      (busy_v[p]),
      .mem_wr    (mwr_v[p])
    );
  end

  dpa_owner u_owner (
    .clk       (clk),
    .rst       (rst),
    .hit       (hit),
    .held_l    (held_v[PL]),
    .held_r    (held_v[PR]),
    .owner_nxt (owner_nxt)
  );

  assign left_busy    = busy_v[PL];
  assign right_busy   = busy_v[PR];
  assign left_mem_wr  = mwr_v[PL];
  assign right_mem_wr = mwr_v[PR];
endmodule

// File: rtl/dpa_chk.sv
module dpa_chk #(
  parameter int unsigned AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          is_master,
  input logic          left_en,
  input logic [AW-1:0] left_addr,
  input logic          right_en,
  input logic [AW-1:0] right_addr,
  input logic          left_busy_in,
  input logic          right_busy_in,
  input logic          left_busy,
  input logic          right_busy,
  input logic          left_mem_wr,
  input logic          right_mem_wr
);
  logic live  = 1'b0;
  logic rst_q = 1'b0;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    live  <= ~rst;
  end

  // R2
  one_busy_chk: assert property (@(posedge clk) disable iff (rst)
    live && $past(is_master) |-> !(left_busy && right_busy));

  // R7
  left_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    left_busy |-> !left_mem_wr);

  // R7
  right_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    right_busy |-> !right_mem_wr);

  // R1
  no_match_idle_chk: assert property (@(posedge clk) disable iff (rst)
    live && $past(is_master) && !$past(left_en && right_en && (left_addr == right_addr))
    |-> !left_busy && !right_busy);

  // R9
  slave_follow_chk: assert property (@(posedge clk) disable iff (rst)
    live && !$past(is_master)
    |-> (left_busy == $past(left_busy_in)) && (right_busy == $past(right_busy_in)));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst_q |-> !left_busy && !right_busy && !left_mem_wr && !right_mem_wr);
endmodule

bind dp_contention_arb dpa_chk #(.AW(AW)) u_dpa_chk (
  .clk           (clk),
  .rst           (rst),
  .is_master     (is_master),
  .left_en       (left_en),
  .left_addr     (left_addr),
  .right_en      (right_en),
  .right_addr    (right_addr),
  .left_busy_in  (left_busy_in),
  .right_busy_in (right_busy_in),
  .left_busy     (left_busy),
  .right_busy    (right_busy),
  .left_mem_wr   (left_mem_wr),
  .right_mem_wr  (right_mem_wr)
);

// File: tb/dp_contention_arb_tb.sv
module dp_contention_arb_tb;
  localparam int AW = 4;
  localparam int VW = 23;
  localparam int NV = 14;

  // fields: master, bin_l, bin_r | en_l, wr_l, addr_l | en_r, wr_r, addr_r |
  //         exp busy_l, busy_r, mem_wr_l, mem_wr_r | requirement number
  localparam logic [VW-1:0] VECS [NV] = '{
    23'b1_10_1_1_0011_0_0_0000_0_0_1_0_1000, // R8 busy_in ignored
    23'b1_00_1_1_0011_1_1_0011_0_1_1_0_0011, // R3 left held first
    23'b1_00_1_1_0011_1_1_0011_0_1_1_0_0111, // R7 right write blocked
    23'b1_00_0_0_0011_1_1_0011_0_0_0_1_0110, // R6 busy falls
    23'b1_00_1_1_0011_1_1_0011_1_0_0_1_0011, // R3 right held first
    23'b1_00_1_1_0011_1_1_0101_0_0_1_1_0001, // R1 addresses differ
    23'b1_00_1_1_0111_1_1_0111_0_1_1_0_0100, // R4 same-cycle move
    23'b1_00_0_0_0111_0_0_0111_0_0_0_0_0110, // R6 both idle
    23'b1_00_1_0_0010_1_0_0010_0_1_0_0_0101, // R5 enable path
    23'b1_00_1_0_0010_1_0_0100_0_0_0_0_0001, // R1 right moves off
    23'b1_00_1_1_0010_1_1_0010_0_1_1_0_0101, // R5 address path
    23'b0_10_1_1_0010_1_1_1001_1_0_0_1_1001, // R9 follows input
    23'b0_00_1_1_0010_1_1_0010_0_0_1_1_1001, // R9 local arb ignored
    23'b1_00_1_1_0010_1_1_0010_0_1_1_0_0010  // R2 one busy only
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic is_master = 1'b1;
  logic left_en = 1'b0, left_wr = 1'b0, right_en = 1'b0, right_wr = 1'b0;
  logic [AW-1:0] left_addr = '0, right_addr = '0;
  logic left_busy_in = 1'b0, right_busy_in = 1'b0;
  logic left_busy, right_busy, left_mem_wr, right_mem_wr;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dp_contention_arb #(.AW(AW)) u_dut (
    .clk(clk), .rst(rst), .is_master(is_master),
    .left_en(left_en), .left_wr(left_wr), .left_addr(left_addr),
    .right_en(right_en), .right_wr(right_wr), .right_addr(right_addr),
    .left_busy_in(left_busy_in), .right_busy_in(right_busy_in),
    .left_busy(left_busy), .right_busy(right_busy),
    .left_mem_wr(left_mem_wr), .right_mem_wr(right_mem_wr)
  );

  function automatic string req_tag(input int n);
    case (n)
      1: return "R1";   2: return "R2";   3: return "R3";
      4: return "R4";   5: return "R5";   6: return "R6";
      7: return "R7";   8: return "R8";   9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check4(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {left_busy, right_busy, left_mem_wr, right_mem_wr};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: busy_l,busy_r,wr_l,wr_r actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic m, input logic el, input logic wl, input logic [AW-1:0] al,
                       input logic er, input logic wrr, input logic [AW-1:0] ar);
    is_master = m; left_en = el; left_wr = wl; left_addr = al;
    right_en = er; right_wr = wrr; right_addr = ar;
    left_busy_in = 1'b0; right_busy_in = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check4("R10 reset state", 4'b0000);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VECS[i];
      is_master     = v[22];
      left_busy_in  = v[21];
      right_busy_in = v[20];
      left_en       = v[19];
      left_wr       = v[18];
      left_addr     = v[17:14];
      right_en      = v[13];
      right_wr      = v[12];
      right_addr    = v[11:8];
      @(negedge clk);
      check4(req_tag(int'(v[3:0])), v[7:4]);
    end

    // directed: reset in the middle of contention (R10)
    drive(1'b1, 1'b1, 1'b1, 4'd6, 1'b1, 1'b1, 4'd6);
    @(negedge clk);
    check4("R4 fresh contention", 4'b0110);
    rst = 1'b1;
    @(negedge clk);
    check4("R10 reset during contention", 4'b0000);
    rst = 1'b0;
    @(negedge clk);
    check4("R10 history cleared, left wins", 4'b0110);

    // directed: one port only, the other idle on the same address (R1)
    drive(1'b1, 1'b0, 1'b0, 4'd6, 1'b1, 1'b1, 4'd6);
    @(negedge clk);
    check4("R1 single enable", 4'b0001);

    // directed: master ignores both busy inputs high (R8)
    drive(1'b1, 1'b1, 1'b1, 4'd1, 1'b1, 1'b1, 4'd2);
    left_busy_in = 1'b1; right_busy_in = 1'b1;
    @(negedge clk);
    check4("R8 inputs ignored in master", 4'b0011);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R10 watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule